// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Sequencer

This block is the CPU-side engine for table-driven vectored interrupts. A one-cycle request pulse is held in a pending flag. When the core signals the end of an instruction and interrupts are enabled, the block takes the request and clears the enable flag. It then runs an acknowledge window, during which the requesting peripheral places an 8-bit vector on the vector lines. The block forms a 16-bit table pointer: the upper byte is a software-loaded interrupt page register and the lower byte is the vector with bit 0 forced to zero.

With the pointer formed, the block saves the current program counter on a downward-growing stack over a byte-wide synchronous memory port. It then reads the two-byte handler address at the pointer and hands the new program counter and stack pointer to the core with a single load strobe. The table is read from memory on every acknowledge, so software may rewrite it between interrupts.

The whole response takes exactly 19 clock cycles. The `busy` output is high for all 19 and `done` marks the last. A request that arrives while the block is busy stays pending. It is taken once the core enables interrupts again.

Top module: `vec_irq_seq`

## Requirements
- R1: After reset the page register reads as zero, the enable flag is clear, `busy`, `done`, `irq_ack`, `mem_we` and `mem_re` are low, and a sequence run without a page write uses page 0x00.
- R2: A request is taken only when it is pending, `ien` is set, `insn_end` is high and the block is idle. Taking it clears `ien` at the same edge.
- R3: Counting the first cycle after the accepting edge as cycle 0, `busy` is high for exactly cycles 0 to 18 and `done` is high only in cycle 18.
- R4: `irq_ack` is high in cycles 1 to 6 and low otherwise. The vector is sampled at the clock edge that ends cycle 6.
- R5: The high byte of the saved PC is written to address SP-1 in cycle 8. The low byte is written to SP-2 in cycle 11. No other writes occur.
- R6: The table pointer is {page, vector[7:1], 0}. The low handler byte is read at the pointer in cycle 14, and the high byte is read at pointer+1 in cycle 16. Read data arrives one cycle after `mem_re`.
- R7: In cycle 18, `pc_out` equals {byte read at pointer+1, byte read at pointer}, `sp_out` equals SP-2, and `pc_load` and `sp_load` are high. Both strobes are low in every other cycle.
- R8: The table is read from memory on each acknowledge. Changing the table contents between two identical interrupts changes `pc_out`.
- R9: A request pulse that arrives while interrupts are disabled, while `insn_end` is low, or during a sequence stays pending. It is taken after `ien` is set again.
- R10: A page write with `page_wr` high loads `page_wdata` into the page register. The new value selects the table page for the next interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request pulse, latched as pending |
| insn_end | input | 1 | Core is at an instruction boundary |
| ien_wr | input | 1 | Write strobe for the enable flag |
| ien_wdata | input | 1 | New enable flag value |
| page_wr | input | 1 | Write strobe for the page register |
| page_wdata | input | 8 | New page register value |
| irq_ack | output | 1 | Acknowledge window to the peripheral |
| irq_vec | input | 8 | Vector from the peripheral |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data the next cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| pc_in | input | 16 | Core program counter at acceptance |
| sp_in | input | 16 | Core stack pointer at acceptance |
| pc_out | output | 16 | Handler address |
| pc_load | output | 1 | Load `pc_out` into the core PC |
| sp_out | output | 16 | Stack pointer after the push |
| sp_load | output | 1 | Load `sp_out` into the core SP |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last cycle of the sequence |
| ien | output | 1 | Interrupt enable flag |

## Verification
The bench sweeps all 256 vector values. Each vector is paired with a page derived arithmetically from it, along with a varied PC and SP. Odd vectors show whether bit 0 is forced low, and pages of 0x00 and 0xFF show whether the page reaches the upper pointer byte unaltered. Because the table content is a function of address, swapping the low and high handler bytes, or reading the wrong entry, shows up as a wrong `pc_out`. Separate scenarios hold a request while interrupts are disabled, while `insn_end` is low, and while a sequence runs, which tells a correctly held pending flag from one that is lost or taken early. A rewritten table separates a fresh memory read from a stale value.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  // phase lengths of the response, in clock cycles
  localparam int ACK_CYC  = 7;
  localparam int PUSH_CYC = 6;
  localparam int LOOK_CYC = 6;
  localparam int TOTAL    = ACK_CYC + PUSH_CYC + LOOK_CYC;
  localparam int CNT_W    = $clog2(TOTAL);

  // cycle indices within the sequence (cycle 0 follows the accepting edge)
  localparam int ACK_FIRST = 1;
  localparam int ACK_LAST  = ACK_CYC - 1;
  localparam int VEC_CAP   = ACK_LAST;
  localparam int WR_HI     = ACK_CYC + 1;
  localparam int WR_LO     = ACK_CYC + 4;
  localparam int RD_LO     = ACK_CYC + PUSH_CYC + 1;
  localparam int RD_HI     = RD_LO + 2;
  localparam int LAST      = TOTAL - 1;

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              insn_end,
  input  logic              ien_wr,
  input  logic              ien_wdata,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              busy,
  output logic              accept,
  output logic              ien,
  output logic [PAGE_W-1:0] page
);
  logic              pend_q, pend_n;
  logic              ien_q, ien_n;
  logic [PAGE_W-1:0] page_q, page_n;

  assign accept = pend_q & ien_q & insn_end & ~busy;

  always_comb begin
    pend_n = (pend_q & ~accept) | irq_req;
    if (accept)      ien_n = 1'b0;
    else if (ien_wr) ien_n = ien_wdata;
    else             ien_n = ien_q;
    page_n = page_wr ? page_wdata : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ien_q  <= 1'b0;
      page_q <= '0;
    end else begin
      pend_q <= pend_n;
      ien_q  <= ien_n;
      page_q <= page_n;
    end
  end

  assign ien  = ien_q;
  assign page = page_q;

  assert_accept_clears_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!ien_q && busy));
  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !accept) |=> pend_q);
endmodule

// File: rtl/irq_phase_ctr.sv
module irq_phase_ctr
  import vec_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output cnt_t cnt
);
  logic busy_q, busy_n;
  cnt_t cnt_q, cnt_n;
  logic at_last;

  assign at_last = busy_q && (cnt_q == cnt_t'(LAST));

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (at_last) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (busy_q) begin
      cnt_n  = cnt_q + cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;

  assert_starts_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));
  assert_steps_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != cnt_t'(LAST)) |=> (busy_q && cnt_q == $past(cnt_q) + cnt_t'(1)));
  assert_ends_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == cnt_t'(LAST)) |=> !busy_q);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  cnt_t              cnt,
  input  logic [PAGE_W-1:0] page,
  input  logic [DATA_W-1:0] vec_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              done
);
  logic [ADDR_W-1:0] pc_q, sp_q, ptr_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] vec_even;
  logic cap_ctx, cap_vec, cap_lo, cap_hi;

  assign vec_even = vec_i & ~DATA_W'(1);
  assign cap_ctx  = accept;
  assign cap_vec  = busy && (cnt == cnt_t'(VEC_CAP));
  assign cap_lo   = busy && (cnt == cnt_t'(RD_LO + 1));
  assign cap_hi   = busy && (cnt == cnt_t'(RD_HI + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      ptr_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (cap_ctx) begin
        pc_q <= pc_i;
        sp_q <= sp_i;
      end
      if (cap_vec) ptr_q <= {page, vec_even};
      if (cap_lo)  lo_q  <= mem_rdata;
      if (cap_hi)  hi_q  <= mem_rdata;
    end
  end

  assign ack = busy && (cnt >= cnt_t'(ACK_FIRST)) && (cnt <= cnt_t'(ACK_LAST));

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    if (busy) begin
      case (cnt)
        cnt_t'(WR_HI): begin
          mem_we    = 1'b1;
          mem_addr  = sp_q - ADDR_W'(1);
          mem_wdata = pc_q[ADDR_W-1:DATA_W];
        end
        cnt_t'(WR_LO): begin
          mem_we    = 1'b1;
          mem_addr  = sp_q - ADDR_W'(2);
          mem_wdata = pc_q[DATA_W-1:0];
        end
        cnt_t'(RD_LO): begin
          mem_re   = 1'b1;
          mem_addr = ptr_q;
        end
        cnt_t'(RD_HI): begin
          mem_re   = 1'b1;
          mem_addr = ptr_q | ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign done = busy && (cnt == cnt_t'(LAST));
  assign pc_o = {hi_q, lo_q};
  assign sp_o = sp_q - ADDR_W'(2);

  assert_single_bus_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack, mem_we, mem_re}));
  assert_table_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && cnt == cnt_t'(RD_LO)) |-> !mem_addr[0]);
  assert_read_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && cnt == cnt_t'(RD_HI)) |-> (mem_addr[ADDR_W-1:1] == $past(mem_addr[ADDR_W-1:1], 2)));
  assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/vec_irq_seq.sv
module vec_irq_seq
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              insn_end,
  input  logic              ien_wr,
  input  logic              ien_wdata,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_wdata,
  output logic              irq_ack,
  input  logic [DATA_W-1:0] irq_vec,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic [ADDR_W-1:0] sp_out,
  output logic              sp_load,
  output logic              busy,
  output logic              done,
  output logic              ien
);
  logic              accept;
  logic [PAGE_W-1:0] page;
  cnt_t              cnt;
  logic              done_w;

  irq_gate #(.PAGE_W(PAGE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .page_wr(page_wr),
    .page_wdata(page_wdata), .busy(busy), .accept(accept), .ien(ien),
    .page(page)
  );

  irq_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .cnt(cnt)
  );

  irq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .cnt(cnt),
    .page(page), .vec_i(irq_vec), .pc_i(pc_in), .sp_i(sp_in),
    .mem_rdata(mem_rdata), .ack(irq_ack), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .pc_o(pc_out), .sp_o(sp_out), .done(done_w)
  );

  assign done    = done_w;
  assign pc_load = done_w;
  assign sp_load = done_w;

  assert_load_with_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (busy && sp_load && !ien));
  assert_no_strobes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!irq_ack && !mem_we && !mem_re && !done));
endmodule

// File: tb/tb_vec_irq_seq.sv
module tb_vec_irq_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req, insn_end, ien_wr, ien_wdata, page_wr;
  logic [7:0]  page_wdata, irq_vec, vec_drv, mem_wdata, mem_rdata, salt;
  logic        irq_ack, mem_we, mem_re, pc_load, sp_load, busy, done, ien;
  logic [15:0] mem_addr, pc_in, sp_in, pc_out, sp_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [15:0] last_pc;

  always #10 clk = ~clk;

  vec_irq_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .page_wr(page_wr),
    .page_wdata(page_wdata), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_in(pc_in),
    .sp_in(sp_in), .pc_out(pc_out), .pc_load(pc_load), .sp_out(sp_out),
    .sp_load(sp_load), .busy(busy), .done(done), .ien(ien)
  );

  // peripheral drives the true vector only inside the acknowledge window
  assign irq_vec = irq_ack ? vec_drv : ~vec_drv;

  function automatic logic [7:0] tbl(input logic [15:0] a, input logic [7:0] s);
    return 8'(a[7:0] * 8'd3 + a[15:8] + s);
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= tbl(mem_addr, salt);

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  task automatic run_irq(input bit wr_pg, input logic [7:0] pg, input logic [7:0] v,
                         input logic [15:0] pc, input logic [15:0] sp);
    int k;
    int nbusy;
    int done_k;
    int nw;
    int nr;
    logic [18:0] ackm;
    int wk[2];
    logic [15:0] wa[2];
    logic [7:0] wd[2];
    int rk[2];
    logic [15:0] ra[2];
    logic [15:0] ptr;
    logic [15:0] pco;
    logic [15:0] spo;
    k = -1; nbusy = 0; done_k = -1; nw = 0; nr = 0; ackm = '0;
    pco = '0; spo = '0;
    for (int i = 0; i < 2; i++) begin wk[i] = -1; wa[i] = '0; wd[i] = '0; rk[i] = -1; ra[i] = '0; end
    @(negedge clk);
    page_wr = wr_pg; page_wdata = pg; ien_wr = 1'b1; ien_wdata = 1'b1;
    pc_in = pc; sp_in = sp; vec_drv = v; irq_req = 1'b1; insn_end = 1'b1;
    @(negedge clk);
    page_wr = 1'b0; ien_wr = 1'b0; irq_req = 1'b0;
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      if (busy) begin
        k++; nbusy++;
        if (k < 19) ackm[k] = irq_ack;
        if (mem_we) begin
          if (nw < 2) begin wk[nw] = k; wa[nw] = mem_addr; wd[nw] = mem_wdata; end
          nw++;
        end
        if (mem_re) begin
          if (nr < 2) begin rk[nr] = k; ra[nr] = mem_addr; end
          nr++;
        end
        if (pc_load || sp_load || done) begin
          if (done_k < 0) done_k = k; else done_k = 99;
          pco = pc_out; spo = sp_out;
          check("R7 both load strobes", {pc_load, sp_load}, 2'b11);
        end
      end else if (k >= 0) break;
    end
    ptr = {pg_eff(wr_pg, pg), v[7:1], 1'b0};
    check("R3 busy length", nbusy, 19);
    check("R3 done cycle", done_k, 18);
    check("R4 ack window", ackm, 19'h0007E);
    check("R2 enable cleared", ien, 1'b0);
    check("R5 write count", nw, 2);
    check("R5 high byte write", {wk[0][7:0], wa[0], wd[0]}, {8'd8, sp - 16'd1, pc[15:8]});
    check("R5 low byte write", {wk[1][7:0], wa[1], wd[1]}, {8'd11, sp - 16'd2, pc[7:0]});
    check("R6 read count", nr, 2);
    check("R6 low entry read", {rk[0][7:0], ra[0]}, {8'd14, ptr});
    check("R6 high entry read", {rk[1][7:0], ra[1]}, {8'd16, ptr | 16'd1});
    check("R7 handler pc", pco, {tbl(ptr | 16'd1, salt), tbl(ptr, salt)});
    check("R7 new sp", spo, sp - 16'd2);
    last_pc = pco;
  endtask

  logic [7:0] cur_page;
  function automatic logic [7:0] pg_eff(input bit wr_pg, input logic [7:0] pg);
    return wr_pg ? pg : cur_page;
  endfunction

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_req = 0; insn_end = 0; ien_wr = 0; ien_wdata = 0;
    page_wr = 0; page_wdata = 0; vec_drv = 0; pc_in = 0; sp_in = 0;
    salt = 8'h11; mem_rdata = 0; cur_page = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    check("R1 reset outputs", {busy, done, irq_ack, mem_we, mem_re, ien, pc_load, sp_load}, 8'h00);

    // R2/R9: request while disabled is held, not taken
    irq_req = 1'b1; insn_end = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    idle(4);
    check("R2 no accept while disabled", busy, 1'b0);
    insn_end = 1'b0; ien_wr = 1'b1; ien_wdata = 1'b1;
    @(negedge clk); ien_wr = 1'b0;
    idle(3);
    check("R2 no accept off boundary", busy, 1'b0);
    insn_end = 1'b1;
    idle(2);
    check("R9 pending request taken", busy, 1'b1);
    // R9: pulse during the sequence
    idle(3);
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    wait_idle();
    idle(3);
    check("R9 held while disabled after done", busy, 1'b0);
    ien_wr = 1'b1; ien_wdata = 1'b1; @(negedge clk); ien_wr = 1'b0;
    idle(1);
    check("R9 held request taken on enable", busy, 1'b1);
    wait_idle();
    idle(2);

    // R1: first full run without a page write uses page 0
    cur_page = 8'h00;
    run_irq(1'b0, 8'h00, 8'h43, 16'h1234, 16'h8000);
    // R10: page write then sweep all vectors (odd ones test bit 0)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pg;
      pg = (v == 0) ? 8'hFF : 8'(v * 37);
      run_irq(1'b1, pg, 8'(v), 16'(v * 16'd257 + 16'h0F0F), 16'(16'hFFF0 - v * 16'd3));
      cur_page = pg;
      idle(1);
    end
    // R10: page retained when not rewritten
    run_irq(1'b0, 8'h00, 8'hA7, 16'hBEEF, 16'h0002);
    // R8: same interrupt, rewritten table
    begin
      logic [15:0] first_pc;
      run_irq(1'b1, 8'h5C, 8'h20, 16'h4000, 16'h7000);
      first_pc = last_pc;
      salt = 8'h99;
      run_irq(1'b1, 8'h5C, 8'h20, 16'h4000, 16'h7000);
      check("R8 table re-read after rewrite", (first_pc != last_pc), 1'b1);
    end
    idle(2);
    finish_run();
  end
endmodule